// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block keeps the machine status word of a processor core, including a stack of privilege and interrupt-enable frames, three deep by default. Frame 0 holds the current privilege level and the global interrupt enable. Frames 1 and 2 hold the older contexts. A trap strobe pushes the stack, switches the core to machine level, and latches the cause code and the faulting PC. It also produces the address the fetch unit jumps to. A return strobe pops the stack. A status write port lets software rewrite the word. A privilege field is replaced only when the written value is a legal level.

The trap target address depends on the privilege level that was current at the time of the trap. Each level gets its own vector, spaced at a fixed step above a base address. The word also carries several fields that the block does not interpret: a memory-translation mode, a floating-point state field and an extension state field. The only logic on them is a read-only summary bit that flags dirty state.

All control pins are plain single-cycle strobes sampled on the rising clock edge. The block accepts an event on every cycle and never applies back-pressure. Every output is registered, so the effect of an event becomes visible one cycle after the edge that sampled it.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the current privilege is machine (3), frames 1 and 2 hold supervisor (1), and all enables, MPRV, FS, XS and VM are 0. The trap target reads base + 0x100, and cause and EPC read 0. With the default base of 0x100 the status word therefore reads 0x04B and the target 0x200.
- R2: On a trap, frame 2 takes frame 1 and frame 1 takes frame 0. Frame 0 becomes machine privilege with its enable cleared, and MPRV is cleared.
- R3: On a trap, the target becomes base + 0x40 times the privilege that was current before the push (default base 0x100, so user 0x100, supervisor 0x140, machine 0x1C0).
- R4: On a trap, the cause output takes trap_cause_i and the EPC output takes trap_epc_i.
- R5: On a return, frame 0 takes frame 1 and frame 1 takes frame 2. Frame 2 becomes user privilege (0) with its enable set to 1.
- R6: Privilege encoding is user = 0, supervisor = 1, machine = 3; the value 2 is illegal. The status word layout is: frame i at bits [3i+1:3i] (privilege) and bit 3i+2 (enable), MPRV at bit 9, FS at [11:10], XS at [13:12], VM at [18:14], and the summary bit at bit 31. A status write takes the enables, MPRV, FS, XS and VM directly. Each privilege field is updated only if the written value is legal; an illegal value leaves that field unchanged.
- R7: Bit 31 of the status word reads 1 exactly when FS or XS equals 3. It cannot be written.
- R8: When strobes coincide, a trap beats a return and a status write, and a return beats a status write.
- R9: Traps and returns leave FS, XS and VM unchanged. A return leaves the trap target, cause and EPC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap entry strobe |
| trap_cause_i | input | CAUSE_W (5) | Cause code of the trap |
| trap_epc_i | input | XLEN (32) | Faulting PC |
| ret_i | input | 1 | Trap return strobe |
| csr_we_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | XLEN (32) | Status word write value |
| priv_o | output | 2 | Current privilege level |
| gie_o | output | 1 | Global interrupt enable |
| trap_pc_o | output | XLEN (32) | Trap target address |
| cause_o | output | CAUSE_W (5) | Saved cause code |
| epc_o | output | XLEN (32) | Saved exception PC |
| status_o | output | XLEN (32) | Status word read value |

## Verification
The bound checker watches the following on every cycle:
- the push and pop movements of the frames, the entry into machine level and the vector offset;
- cause and EPC capture, and that the summary bit agrees with FS and XS;
- the MPRV write path, and that no privilege field ever holds the illegal encoding.

Only the bench's scenarios show the rest:
- the exact reset word;
- the outcome of coinciding strobes;
- mixed legal and illegal writes across fields;
- that FS, XS, VM and the trap registers survive traps and returns untouched.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [1:0] {
    PL_USER    = 2'd0,
    PL_SUPER   = 2'd1,
    PL_RSVD    = 2'd2,
    PL_MACHINE = 2'd3
  } priv_lvl_e;

  // One stack frame: enable above privilege, three bits total
  typedef struct packed {
    logic       ien;
    logic [1:0] lvl;
  } frame_t;

  localparam int unsigned FRAME_W = 3;
  localparam logic [1:0] STATE_DIRTY = 2'b11;

  function automatic logic lvl_legal(logic [1:0] v);
    return v != PL_RSVD;
  endfunction

endpackage

// File: rtl/priv_csr_filter.sv
module priv_csr_filter
  import priv_trap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned VM_W  = 5
) (
  input  logic [XLEN-1:0]        wdata_i,
  input  frame_t [DEPTH-1:0]     frames_i,
  output frame_t [DEPTH-1:0]     frames_o,
  output logic                   mprv_o,
  output logic [1:0]             fs_o,
  output logic [1:0]             xs_o,
  output logic [VM_W-1:0]        vm_o
);
  localparam int unsigned MPRV_B = FRAME_W * DEPTH;
  localparam int unsigned FS_LO  = MPRV_B + 1;
  localparam int unsigned XS_LO  = MPRV_B + 3;
  localparam int unsigned VM_LO  = MPRV_B + 5;
  localparam int unsigned USED   = VM_LO + VM_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_frame
    frame_t wr;
    assign wr = frame_t'(wdata_i[FRAME_W*g +: FRAME_W]);
    assign frames_o[g].ien = wr.ien;
    assign frames_o[g].lvl = lvl_legal(wr.lvl) ? wr.lvl : frames_i[g].lvl;
  end

  assign mprv_o = wdata_i[MPRV_B];
  assign fs_o   = wdata_i[FS_LO +: 2];
  assign xs_o   = wdata_i[XS_LO +: 2];
  assign vm_o   = wdata_i[VM_LO +: VM_W];

  // Read-only and reserved bits of the write value are dropped
  logic unused_hi;
  assign unused_hi = ^wdata_i[XLEN-1:USED];

endmodule

// File: rtl/priv_stack.sv
module priv_stack
  import priv_trap_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned VM_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic               ret_i,
  input  logic               csr_we_i,
  input  frame_t [DEPTH-1:0] wr_frames_i,
  input  logic               wr_mprv_i,
  input  logic [1:0]         wr_fs_i,
  input  logic [1:0]         wr_xs_i,
  input  logic [VM_W-1:0]    wr_vm_i,
  output frame_t [DEPTH-1:0] frames_o,
  output logic               mprv_o,
  output logic [1:0]         fs_o,
  output logic [1:0]         xs_o,
  output logic [VM_W-1:0]    vm_o
);
  frame_t [DEPTH-1:0] push_nxt, pop_nxt;
  logic do_push, do_pop, do_wr;

  // Trap over return over status write
  assign do_push = trap_i;
  assign do_pop  = ret_i & ~trap_i;
  assign do_wr   = csr_we_i & ~trap_i & ~ret_i;

  always_comb begin
    push_nxt[0] = '{ien: 1'b0, lvl: PL_MACHINE};
    for (int i = 1; i < DEPTH; i++) push_nxt[i] = frames_o[i-1];
    for (int i = 0; i < DEPTH - 1; i++) pop_nxt[i] = frames_o[i+1];
    pop_nxt[DEPTH-1] = '{ien: 1'b1, lvl: PL_USER};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frames_o[0] <= '{ien: 1'b0, lvl: PL_MACHINE};
      for (int i = 1; i < DEPTH; i++) frames_o[i] <= '{ien: 1'b0, lvl: PL_SUPER};
      mprv_o <= 1'b0;
      fs_o   <= '0;
      xs_o   <= '0;
      vm_o   <= '0;
    end else if (do_push) begin
      frames_o <= push_nxt;
      mprv_o   <= 1'b0;
    end else if (do_pop) begin
      frames_o <= pop_nxt;
    end else if (do_wr) begin
      frames_o <= wr_frames_i;
      mprv_o   <= wr_mprv_i;
      fs_o     <= wr_fs_i;
      xs_o     <= wr_xs_i;
      vm_o     <= wr_vm_i;
    end
  end

endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     CAUSE_W   = 5,
  parameter logic [XLEN-1:0] VEC_BASE  = 'h100,
  parameter int unsigned     VEC_STEP  = 'h40,
  parameter int unsigned     BOOT_OFF  = 'h100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic [1:0]         cur_lvl_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    epc_i,
  output logic [XLEN-1:0]    trap_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o
);
  localparam logic [XLEN-1:0] BOOT_PC = VEC_BASE + XLEN'(BOOT_OFF);

  logic [XLEN-1:0] vec_nxt;
  assign vec_nxt = VEC_BASE + XLEN'(cur_lvl_i) * XLEN'(VEC_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_pc_o <= BOOT_PC;
      cause_o   <= '0;
      epc_o     <= '0;
    end else if (trap_i) begin
      trap_pc_o <= vec_nxt;
      cause_o   <= cause_i;
      epc_o     <= epc_i;
    end
  end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     DEPTH    = 3,
  parameter int unsigned     VM_W     = 5,
  parameter int unsigned     CAUSE_W  = 5,
  parameter logic [XLEN-1:0] VEC_BASE = 'h100,
  parameter int unsigned     VEC_STEP = 'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_epc_i,
  input  logic               ret_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [1:0]         priv_o,
  output logic               gie_o,
  output logic [XLEN-1:0]    trap_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    status_o
);
  localparam int unsigned MPRV_B = FRAME_W * DEPTH;
  localparam int unsigned FS_LO  = MPRV_B + 1;
  localparam int unsigned XS_LO  = MPRV_B + 3;
  localparam int unsigned VM_LO  = MPRV_B + 5;
  localparam int unsigned USED   = VM_LO + VM_W;

  frame_t [DEPTH-1:0] frames, wr_frames;
  logic               mprv, wr_mprv;
  logic [1:0]         fs, xs, wr_fs, wr_xs;
  logic [VM_W-1:0]    vm, wr_vm;

  priv_csr_filter #(.XLEN(XLEN), .DEPTH(DEPTH), .VM_W(VM_W)) u_filter (
    .wdata_i  (csr_wdata_i),
    .frames_i (frames),
    .frames_o (wr_frames),
    .mprv_o   (wr_mprv),
    .fs_o     (wr_fs),
    .xs_o     (wr_xs),
    .vm_o     (wr_vm)
  );

  priv_stack #(.DEPTH(DEPTH), .VM_W(VM_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trap_i      (trap_i),
    .ret_i       (ret_i),
    .csr_we_i    (csr_we_i),
    .wr_frames_i (wr_frames),
    .wr_mprv_i   (wr_mprv),
    .wr_fs_i     (wr_fs),
    .wr_xs_i     (wr_xs),
    .wr_vm_i     (wr_vm),
    .frames_o    (frames),
    .mprv_o      (mprv),
    .fs_o        (fs),
    .xs_o        (xs),
    .vm_o        (vm)
  );

  trap_vec_gen #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_i    (trap_i),
    .cur_lvl_i (frames[0].lvl),
    .cause_i   (trap_cause_i),
    .epc_i     (trap_epc_i),
    .trap_pc_o (trap_pc_o),
    .cause_o   (cause_o),
    .epc_o     (epc_o)
  );

  assign priv_o = frames[0].lvl;
  assign gie_o  = frames[0].ien;

  always_comb begin
    status_o = '0;
    status_o[MPRV_B - 1:0]  = frames;
    status_o[MPRV_B]        = mprv;
    status_o[FS_LO +: 2]    = fs;
    status_o[XS_LO +: 2]    = xs;
    status_o[VM_LO +: VM_W] = vm;
    status_o[XLEN-1]        = (fs == STATE_DIRTY) | (xs == STATE_DIRTY);
  end

endmodule

// File: rtl/priv_trap_ctrl_chk.sv
module priv_trap_ctrl_chk #(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     DEPTH    = 3,
  parameter int unsigned     VM_W     = 5,
  parameter int unsigned     CAUSE_W  = 5,
  parameter logic [XLEN-1:0] VEC_BASE = 'h100,
  parameter int unsigned     VEC_STEP = 'h40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trap_i,
  input logic [CAUSE_W-1:0] trap_cause_i,
  input logic [XLEN-1:0]    trap_epc_i,
  input logic               ret_i,
  input logic               csr_we_i,
  input logic [XLEN-1:0]    csr_wdata_i,
  input logic [1:0]         priv_o,
  input logic               gie_o,
  input logic [XLEN-1:0]    trap_pc_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [XLEN-1:0]    status_o
);
  localparam int unsigned MPRV_B = 3 * DEPTH;
  localparam int unsigned FS_LO  = MPRV_B + 1;
  localparam int unsigned XS_LO  = MPRV_B + 3;
  localparam int unsigned TOP_F  = 3 * (DEPTH - 1);

  a_r2_enter_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o == 2'd3) && !gie_o && !status_o[MPRV_B]);

  a_r2_save_current: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> status_o[3 +: 3] == $past(status_o[0 +: 3]));

  a_r5_pop_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !trap_i) |=> (status_o[0 +: 3] == $past(status_o[3 +: 3]))
                           && (status_o[TOP_F +: 3] == 3'b100));

  a_r3_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> trap_pc_o == VEC_BASE + XLEN'($past(priv_o)) * XLEN'(VEC_STEP));

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (cause_o == $past(trap_cause_i)) && (epc_o == $past(trap_epc_i)));

  a_r7_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[XLEN-1] == ((status_o[FS_LO +: 2] == 2'b11) || (status_o[XS_LO +: 2] == 2'b11)));

  a_r8_write_mprv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !trap_i && !ret_i) |=> status_o[MPRV_B] == $past(csr_wdata_i[MPRV_B]));

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    a_r6_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[3*g +: 2] != 2'd2);
  end

endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(
  .XLEN(XLEN), .DEPTH(DEPTH), .VM_W(VM_W), .CAUSE_W(CAUSE_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (.*);

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        trap_i = 0, ret_i = 0, csr_we_i = 0;
  logic [4:0]  trap_cause_i = '0;
  logic [31:0] trap_epc_i = '0, csr_wdata_i = '0;
  logic [1:0]  priv_o;
  logic        gie_o;
  logic [31:0] trap_pc_o, epc_o, status_o;
  logic [4:0]  cause_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  priv_trap_ctrl uut (.*);

  // {op[2]=trap op[1]=ret op[0]=write, arg, expected status[9:0]}
  localparam logic [44:0] VEC [10] = '{
    {3'b001, 32'h0000_03E5, 10'h3E5},
    {3'b100, 32'h0000_1000, 10'h12B},
    {3'b010, 32'h0000_0000, 10'h125},
    {3'b010, 32'h0000_0000, 10'h124},
    {3'b100, 32'h0000_2000, 10'h123},
    {3'b001, 32'h0000_009A, 10'h01B},
    {3'b110, 32'h0000_3000, 10'h0DB},
    {3'b011, 32'h0000_0000, 10'h11B},
    {3'b101, 32'h0000_03E5, 10'h0DB},
    {3'b001, 32'h0000_0000, 10'h000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [31:0] arg);
    @(negedge clk_i);
    trap_i = op[2]; ret_i = op[1]; csr_we_i = op[0];
    csr_wdata_i = arg; trap_epc_i = arg; trap_cause_i = arg[4:0];
    @(negedge clk_i);
    trap_i = 0; ret_i = 0; csr_we_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 status", status_o, 32'h0000_004B);
    chk("R1 priv", {30'd0, priv_o}, 32'd3);
    chk("R1 gie", {31'd0, gie_o}, 32'd0);
    chk("R1 target", trap_pc_o, 32'h200);
    chk("R1 cause", {27'd0, cause_o}, 32'd0);
    chk("R1 epc", epc_o, 32'd0);

    for (int i = 0; i < 10; i++) begin
      apply(VEC[i][44:42], VEC[i][41:10]);
      chk($sformatf("R2 R5 R6 R8 row %0d", i), {22'd0, status_o[9:0]}, {22'd0, VEC[i][9:0]});
    end

    // R3 / R4 vectors by level
    apply(3'b001, 32'h1);
    apply(3'b100, 32'h1234);
    chk("R3 from super", trap_pc_o, 32'h140);
    chk("R4 cause", {27'd0, cause_o}, 32'h14);
    chk("R4 epc", epc_o, 32'h1234);
    apply(3'b100, 32'h88);
    chk("R3 from machine", trap_pc_o, 32'h1C0);
    apply(3'b010, 32'h0);
    chk("R9 ret keeps target", trap_pc_o, 32'h1C0);
    chk("R9 ret keeps cause", {27'd0, cause_o}, 32'h08);
    chk("R9 ret keeps epc", epc_o, 32'h88);
    apply(3'b001, 32'h0);
    apply(3'b100, 32'h40);
    chk("R3 from user", trap_pc_o, 32'h100);

    // R7 summary bit
    apply(3'b001, 32'h0000_0C03);
    chk("R7 fs dirty", {31'd0, status_o[31]}, 32'd1);
    apply(3'b001, 32'h0000_3003);
    chk("R7 xs dirty", {31'd0, status_o[31]}, 32'd1);
    apply(3'b001, 32'h0000_1803);
    chk("R7 clean", {31'd0, status_o[31]}, 32'd0);
    apply(3'b001, 32'h8000_0003);
    chk("R7 not writable", {31'd0, status_o[31]}, 32'd0);

    // R6 / R9 VM, FS, XS passthrough and preservation
    apply(3'b001, 32'h0005_4C03);
    chk("R6 vm fs written", {23'd0, status_o[18:10]}, 32'h153);
    apply(3'b100, 32'h0);
    chk("R9 trap keeps vm fs xs", {23'd0, status_o[18:10]}, 32'h153);
    apply(3'b010, 32'h0);
    chk("R9 ret keeps vm fs xs", {23'd0, status_o[18:10]}, 32'h153);

    done = 1;
    finish_run();
  end

endmodule